// File: doc/BRIEF.md
# Single-Clock Enable Strobe Generator

This block produces all the timing for a retro home-computer core from one master clock. It does not derive any second clock and does not multiplex clocks. Instead it counts master cycles and issues registered enable strobes that last one cycle each. Downstream logic runs at a slower effective rate by acting only on the cycles in which its strobe is high.

There are two independent dividers. The pixel divider drives the shift-register enable. With a 32 MHz master and `PIX_DIV` = 4, that enable gives an 8 MHz shift rate. The CPU divider divides by the parameter `CPU_DIV` and builds a two-phase bus cycle from that count. The first half of the cycle is low and lasts floor(`CPU_DIV`/2) master cycles. The second half is high and lasts ceil(`CPU_DIV`/2) cycles. Each half ends with a fetch strobe, which tells the video logic to sample the data bus, so the bus is sampled twice per CPU cycle. The CPU enable fires in the same cycle as the fetch strobe that closes the high half.

The default is a 32 MHz master divided by 33, which gives about 0.97 MHz. The block must also work with a 64 MHz master divided by 65, which gives about 0.985 MHz.

Top module: `tick_sequencer`

## Requirements
- R1: Reset is synchronous and active high. If `rst_i` is high at a clock edge, then in the following cycle every strobe output is 0 and `phase_o` is 0 (low half).
- R2: Number the master cycles after reset release from 1. The first cycle is the one that ends at the first edge with `rst_i` low. `pix_en_o` is 1 exactly in the cycles that are multiples of `PIX_DIV`.
- R3: The pixel divider does not depend on the CPU divider. Its pulse spacing of `PIX_DIV` continues unbroken across the boundaries between CPU cycles, including when `CPU_DIV` is not a multiple of `PIX_DIV`.
- R4: Within each CPU cycle of `CPU_DIV` master cycles, `phase_o` is 0 for the first floor(`CPU_DIV`/2) cycles and 1 for the remaining ceil(`CPU_DIV`/2) cycles. It returns to 0 at the start of the next CPU cycle.
- R5: `fetch_lo_o` is 1 only in the last cycle of the low half, which is cycle floor(`CPU_DIV`/2) of each CPU cycle.
- R6: `fetch_hi_o` is 1 only in the last cycle of the high half, which is cycle `CPU_DIV` of each CPU cycle.
- R7: `cpu_en_o` is 1 in exactly the same cycles as `fetch_hi_o`. Its first pulse falls in cycle `CPU_DIV` after reset release, and later pulses repeat every `CPU_DIV` cycles.
- R8: No strobe output (`pix_en_o`, `cpu_en_o`, `fetch_lo_o`, `fetch_hi_o`) is ever 1 in two consecutive cycles. The two fetch strobes are never 1 together.
- R9: The same behaviour holds with `CPU_DIV` = 65, which is the 64 MHz configuration.
- R10: Asserting reset in the middle of a CPU cycle restarts both dividers. After release, the sequence repeats from cycle 1 exactly as it does after the first reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock; the only clock of the block |
| rst_i | input | 1 | Synchronous reset, active high |
| pix_en_o | output | 1 | Pixel shift enable, one cycle in every `PIX_DIV` |
| cpu_en_o | output | 1 | CPU cycle enable, one cycle in every `CPU_DIV` |
| phase_o | output | 1 | Bus phase level: 0 = low half, 1 = high half |
| fetch_lo_o | output | 1 | Bus fetch strobe at the end of the low half |
| fetch_hi_o | output | 1 | Bus fetch strobe at the end of the high half |

## Verification
Every output comes from a register that is loaded with the decode of the counter's next value. The value seen during master cycle j therefore reflects a count of j−1, and a reset seen at an edge takes effect in the very next cycle with no extra latency. The bench releases reset on a falling edge and samples once per falling edge, and that sample is cycle j. The expected values are computed for that same j from the divide formulas: pixel pulses at multiples of `PIX_DIV`, and phase and fetch positions at count floor(N/2)−1 and N−1 modulo N. Two dividers run side by side, one with N = 33 and one with N = 65, and a reset in mid-cycle restarts the numbering at cycle 1.

// File: rtl/tick_pkg.sv
package tick_pkg;

   // Bundle of registered timing outputs
   typedef struct packed {
      logic pix;
      logic phase;
      logic fetch_lo;
      logic fetch_hi;
      logic cpu;
   } tick_bus_t;

   // True when v is a power of two (and nonzero)
   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   // Counter width able to hold 0 .. m-1
   function automatic int cnt_width(input int m);
      return (m > 2) ? $clog2(m) : 1;
   endfunction

endpackage

// File: rtl/tick_modcnt.sv
module tick_modcnt
   import tick_pkg::*;
#(
   parameter int MOD = 4,
   localparam int W = cnt_width(MOD)
)(
   input  logic         clk_i,
   input  logic         rst_i,
   output logic [W-1:0] cnt_q,
   output logic [W-1:0] cnt_nxt
);

   localparam logic [W-1:0] LAST = W'(MOD - 1);

   if (MOD < 2) begin : g_bad_mod
      $error("tick_modcnt: MOD must be at least 2");
   end

   // Variant choice: an exact power of two wraps naturally
   if (is_pow2(MOD) && ((1 << W) == MOD)) begin : g_wrap
      always_comb cnt_nxt = cnt_q + 1'b1;
   end else begin : g_cmp
      always_comb cnt_nxt = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) cnt_q <= '0;
      else       cnt_q <= cnt_nxt;
   end

   p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      cnt_q <= LAST);

endmodule

// File: rtl/tick_pix_decode.sv
module tick_pix_decode
   import tick_pkg::*;
#(
   parameter int PIX_DIV = 4,
   localparam int W = cnt_width(PIX_DIV)
)(
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [W-1:0] cnt_nxt,
   output logic         pix_q
);

   localparam logic [W-1:0] LAST = W'(PIX_DIV - 1);

   always_ff @(posedge clk_i) begin
      if (rst_i) pix_q <= 1'b0;
      else       pix_q <= (cnt_nxt == LAST);
   end

   p_pix_single_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      pix_q |=> !pix_q);

endmodule

// File: rtl/tick_cpu_decode.sv
module tick_cpu_decode
   import tick_pkg::*;
#(
   parameter int CPU_DIV = 33,
   localparam int W = cnt_width(CPU_DIV)
)(
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [W-1:0] cnt_nxt,
   output logic         phase_q,
   output logic         fetch_lo_q,
   output logic         fetch_hi_q,
   output logic         cpu_q
);

   localparam int           LO_LEN  = CPU_DIV / 2;
   localparam logic [W-1:0] LO_END  = W'(LO_LEN - 1);
   localparam logic [W-1:0] HI_BEG  = W'(LO_LEN);
   localparam logic [W-1:0] HI_END  = W'(CPU_DIV - 1);

   if (CPU_DIV < 4) begin : g_bad_div
      $error("tick_cpu_decode: CPU_DIV must be at least 4");
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         phase_q    <= 1'b0;
         fetch_lo_q <= 1'b0;
         fetch_hi_q <= 1'b0;
         cpu_q      <= 1'b0;
      end else begin
         phase_q    <= (cnt_nxt >= HI_BEG);
         fetch_lo_q <= (cnt_nxt == LO_END);
         fetch_hi_q <= (cnt_nxt == HI_END);
         cpu_q      <= (cnt_nxt == HI_END);
      end
   end

   p_lo_in_low_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      fetch_lo_q |-> !phase_q);
   p_lo_then_high_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      fetch_lo_q |=> phase_q);
   p_rise_after_lo_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(phase_q) |-> $past(fetch_lo_q));
   p_hi_in_high_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      fetch_hi_q |-> phase_q);
   p_hi_then_low_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      fetch_hi_q |=> !phase_q);
   p_cpu_with_hi_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      cpu_q == fetch_hi_q);
   p_fetch_excl_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      !(fetch_lo_q && fetch_hi_q));

endmodule

// File: rtl/tick_sequencer.sv
module tick_sequencer
   import tick_pkg::*;
#(
   parameter int PIX_DIV = 4,
   parameter int CPU_DIV = 33
)(
   input  logic clk_i,
   input  logic rst_i,
   output logic pix_en_o,
   output logic cpu_en_o,
   output logic phase_o,
   output logic fetch_lo_o,
   output logic fetch_hi_o
);

   localparam int PW = cnt_width(PIX_DIV);
   localparam int CW = cnt_width(CPU_DIV);

   if (PIX_DIV < 2) begin : g_bad_pix
      $error("tick_sequencer: PIX_DIV must be at least 2");
   end

   logic [PW-1:0] pix_cnt, pix_nxt;
   logic [CW-1:0] cpu_cnt, cpu_nxt;
   tick_bus_t     bus;

   tick_modcnt #(.MOD(PIX_DIV)) i_pix_cnt (
      .clk_i(clk_i), .rst_i(rst_i), .cnt_q(pix_cnt), .cnt_nxt(pix_nxt));

   tick_modcnt #(.MOD(CPU_DIV)) i_cpu_cnt (
      .clk_i(clk_i), .rst_i(rst_i), .cnt_q(cpu_cnt), .cnt_nxt(cpu_nxt));

   tick_pix_decode #(.PIX_DIV(PIX_DIV)) i_pix_dec (
      .clk_i(clk_i), .rst_i(rst_i), .cnt_nxt(pix_nxt), .pix_q(bus.pix));

   tick_cpu_decode #(.CPU_DIV(CPU_DIV)) i_cpu_dec (
      .clk_i(clk_i), .rst_i(rst_i), .cnt_nxt(cpu_nxt),
      .phase_q(bus.phase), .fetch_lo_q(bus.fetch_lo),
      .fetch_hi_q(bus.fetch_hi), .cpu_q(bus.cpu));

   assign pix_en_o   = bus.pix;
   assign cpu_en_o   = bus.cpu;
   assign phase_o    = bus.phase;
   assign fetch_lo_o = bus.fetch_lo;
   assign fetch_hi_o = bus.fetch_hi;

   // Independent spacing monitors: cycles since reset or last pulse
   logic [PW-1:0] pix_gap;
   logic [CW-1:0] cpu_gap;
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pix_gap <= '0;
         cpu_gap <= '0;
      end else begin
         pix_gap <= pix_en_o ? '0 : pix_gap + 1'b1;
         cpu_gap <= cpu_en_o ? '0 : cpu_gap + 1'b1;
      end
   end

   p_reset_quiet_r1: assert property (@(posedge clk_i)
      rst_i |=> !(pix_en_o || cpu_en_o || phase_o || fetch_lo_o || fetch_hi_o));
   p_pix_spacing_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      pix_en_o |-> (pix_gap == PW'(PIX_DIV - 1)));
   p_cpu_spacing_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      cpu_en_o |-> (cpu_gap == CW'(CPU_DIV - 1)));
   p_cpu_single_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      cpu_en_o |=> !cpu_en_o);
   p_lo_single_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      fetch_lo_o |=> !fetch_lo_o);

endmodule

// File: tb/test_tick_sequencer.sv
module test_tick_sequencer;

   localparam int P  = 4;
   localparam int NA = 33;
   localparam int NB = 65;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   logic a_pix, a_cpu, a_ph, a_lo, a_hi;
   logic b_pix, b_cpu, b_ph, b_lo, b_hi;

   tick_sequencer #(.PIX_DIV(P), .CPU_DIV(NA)) i_tick_sequencer (
      .clk_i(clk), .rst_i(rst), .pix_en_o(a_pix), .cpu_en_o(a_cpu),
      .phase_o(a_ph), .fetch_lo_o(a_lo), .fetch_hi_o(a_hi));

   tick_sequencer #(.PIX_DIV(P), .CPU_DIV(NB)) i_tick_sequencer_b (
      .clk_i(clk), .rst_i(rst), .pix_en_o(b_pix), .cpu_en_o(b_cpu),
      .phase_o(b_ph), .fetch_lo_o(b_lo), .fetch_hi_o(b_hi));

   int n_chk  = 0;
   int n_fail = 0;

   // Spot vectors for CPU_DIV=33: {cycle, pix, phase, fetch_lo, fetch_hi/cpu}
   typedef struct packed {
      logic [15:0] cyc;
      logic        pix;
      logic        ph;
      logic        lo;
      logic        hi;
   } vec_t;
   localparam int NV = 12;
   localparam vec_t VT [NV] = '{
      '{16'd1,  1'b0, 1'b0, 1'b0, 1'b0},
      '{16'd4,  1'b1, 1'b0, 1'b0, 1'b0},
      '{16'd16, 1'b1, 1'b0, 1'b1, 1'b0},
      '{16'd17, 1'b0, 1'b1, 1'b0, 1'b0},
      '{16'd32, 1'b1, 1'b1, 1'b0, 1'b0},
      '{16'd33, 1'b0, 1'b1, 1'b0, 1'b1},
      '{16'd34, 1'b0, 1'b0, 1'b0, 1'b0},
      '{16'd36, 1'b1, 1'b0, 1'b0, 1'b0},
      '{16'd49, 1'b0, 1'b0, 1'b1, 1'b0},
      '{16'd50, 1'b0, 1'b1, 1'b0, 1'b0},
      '{16'd66, 1'b0, 1'b1, 1'b0, 1'b1},
      '{16'd68, 1'b1, 1'b0, 1'b0, 1'b0}
   };

   task automatic chk(input string req, input string what,
                      input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // Expected bits in cycle j for divide n: {pix, phase, lo, hi, cpu}
   function automatic logic [4:0] expect_bits(input int j, input int n);
      int m = (j - 1) % n;
      return {((j - 1) % P) == P - 1, m >= n / 2, m == n / 2 - 1,
              m == n - 1, m == n - 1};
   endfunction

   logic [4:0] prev_a, prev_b;

   // Compare one sample of both instances against the formula
   task automatic check_cycle(input int j, input string tag);
      logic [4:0] ea, eb, aa, ab;
      ea = expect_bits(j, NA);
      eb = expect_bits(j, NB);
      aa = {a_pix, a_ph, a_lo, a_hi, a_cpu};
      ab = {b_pix, b_ph, b_lo, b_hi, b_cpu};
      if (tag == "R10") begin
         chk("R10", "A bundle", 1'(aa == ea), 1'b1);
         chk("R10", "B bundle", 1'(ab == eb), 1'b1);
      end else begin
         chk(j > NA ? "R3" : "R2", "pix", a_pix, ea[4]);
         chk("R4", "phase", a_ph, ea[3]);
         chk("R5", "fetch_lo", a_lo, ea[2]);
         chk("R6", "fetch_hi", a_hi, ea[1]);
         chk("R7", "cpu_en", a_cpu, ea[0]);
         chk("R9", "B bundle", 1'(ab == eb), 1'b1);
      end
      if (j > 1) begin
         chk("R8", "A no repeat",
             1'((prev_a & aa & 5'b10111) == 5'b0 && !(a_lo && a_hi)), 1'b1);
         chk("R8", "B no repeat",
             1'((prev_b & ab & 5'b10111) == 5'b0 && !(b_lo && b_hi)), 1'b1);
      end
      prev_a = aa;
      prev_b = ab;
   endtask

   task automatic next_cycle();
      @(posedge clk);
      @(negedge clk);
   endtask

   // Watchdog
   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual expired expected done");
      summary();
   end

   initial begin
      int vi;
      repeat (3) @(negedge clk);
      // R1: reset state visible while reset is held
      chk("R1", "bundle in reset",
          1'({a_pix, a_ph, a_lo, a_hi, a_cpu, b_pix, b_ph, b_lo, b_hi, b_cpu} == 10'b0),
          1'b1);
      rst = 1'b0;
      vi = 0;
      for (int j = 1; j <= 140; j++) begin
         check_cycle(j, "");
         if (vi < NV && int'(VT[vi].cyc) == j) begin
            chk("R2", "vec pix", a_pix, VT[vi].pix);
            chk("R4", "vec phase", a_ph, VT[vi].ph);
            chk("R5", "vec lo", a_lo, VT[vi].lo);
            chk("R6", "vec hi", a_hi, VT[vi].hi);
            vi++;
         end
         next_cycle();
      end

      // Reset in the middle of a CPU cycle (A is at count 140%33 region)
      repeat (7) next_cycle();
      rst = 1'b1;
      next_cycle();
      chk("R1", "mid-run reset quiet",
          1'({a_pix, a_ph, a_lo, a_hi, a_cpu, b_pix, b_ph, b_lo, b_hi, b_cpu} == 10'b0),
          1'b1);
      rst = 1'b0;
      for (int j = 1; j <= 70; j++) begin
         check_cycle(j, "R10");
         next_cycle();
      end
      // Directed: first CPU enable lands exactly in cycle N after release
      rst = 1'b1;
      next_cycle();
      rst = 1'b0;
      for (int j = 1; j <= NA; j++) begin
         if (j == NA) chk("R7", "first cpu_en", a_cpu, 1'b1);
         else if (a_cpu) chk("R7", "early cpu_en", a_cpu, 1'b0);
         next_cycle();
      end
      summary();
   end

endmodule